// File: doc/BRIEF.md
# Add-Side Frame Timing Generator

This block generates the add-side timing of a byte-serial SONET frame of 270 columns by 9 rows, which is 2430 byte slots per frame. On every byte clock it says whether the slot is the frame reference (C1). It also says whether the slot carries the payload start (J1), whether the slot lies inside the synchronous payload envelope, and whether the add data lane is active. It gates the 8-bit add data and appends an odd parity bit. One byte clock drives all of the logic. The frame references from the different sources all arrive as one-cycle strobes on that clock.

Two mode pins pick the timing source. The first source is the drop-side frame pulse, with a programmable slot offset. The second is the add bus itself, where an incoming C1/J1 strobe and an incoming SPE level set the frame and the payload start. The third is an external frame pulse that may be absent; the same offset absorbs up to one frame of delay on it. Without a reference the frame counter runs free. In the two generated modes, J1 sits at one of two fixed pointer positions. A mode change waits for the current frame to end, so no short frame is ever emitted.

Top module: `sfg_add_timing`

## Requirements
- R1: In drop or external mode, with no reference strobe, `c1_out` pulses for one cycle every 2430 cycles.
- R2: In drop or external mode, `spe_out` is low in columns 0 to 8 of each row and high in columns 9 to 269. Slot s lies in column s mod 270.
- R3: In drop or external mode, `c1j1_out` is high in slot 0 (C1) and in the J1 slot. The J1 slot is slot 819 (row 3, column 9) when `ptr_high_sel`=0 (pointer 0) and slot 9 (row 0, column 9) when `ptr_high_sel`=1 (pointer 522).
- R4: A reference strobe sampled with `ref_offset`=k marks that cycle as slot k. The counter then holds slot (k+1) mod 2430 and `c1_out` follows 2430-k cycles after the strobe's own output cycle. A value of k above 2429 counts as 0. The strobe is `drop_c1` in drop mode and `ext_c1` in external mode.
- R5: The mode pins select the source. `tm_add_sel`=1 selects add-bus mode. `tm_add_sel`=0 with `tm_drop_sel`=1 selects drop mode. Both low selects external mode. The strobe of the unselected source has no effect on the outputs.
- R6: In add-bus mode, `c1_out`, `c1j1_out` and `spe_out` stay low. `add_c1j1_in` with `add_spe_in`=0 restarts the frame, so the next slot is 1. `add_c1j1_in` with `add_spe_in`=1 marks J1. `add_spe_in` defines the payload slots.
- R7: `add_en_out` is low until the first J1 of the current mode. From the J1 slot onward it is high on every payload slot. `add_data_out` equals the sampled data when `add_en_out` is high and is zero otherwise.
- R8: `parity_out` makes the nine bits {`parity_out`, `add_data_out`} hold an odd number of ones, in the same cycle as the data.
- R9: The mode present on the pins at the first clock after reset applies at once. A later change applies from the slot after slot 2429 of the running frame.
- R10: All outputs are registered. The output in cycle n+1 describes the slot held in cycle n, with the data sampled in cycle n. During reset the outputs are zero, except `parity_out`, which is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tm_add_sel | input | 1 | Selects add-bus timing when high |
| tm_drop_sel | input | 1 | When add-bus timing is off: high selects drop timing, low selects external timing |
| ptr_high_sel | input | 1 | J1 at pointer 522 when high, at pointer 0 when low |
| drop_c1 | input | 1 | Drop-side frame reference strobe |
| ext_c1 | input | 1 | External frame reference strobe (optional) |
| ref_offset | input | 12 | Slot index that a reference strobe stands for |
| add_c1j1_in | input | 1 | Incoming add-bus C1/J1 strobe |
| add_spe_in | input | 1 | Incoming add-bus payload level |
| add_data_in | input | 8 | Add data to be placed |
| c1_out | output | 1 | Frame reference pulse |
| c1j1_out | output | 1 | Combined C1/J1 indicator |
| spe_out | output | 1 | Payload-column indicator |
| add_en_out | output | 1 | Add lane active |
| add_data_out | output | 8 | Gated add data |
| parity_out | output | 1 | Odd parity over add_data_out |

## Verification
Three events can fall on the same clock: the last slot of a frame, a pending mode change, and a reference strobe. The bench requests a switch from drop mode to external mode and pulses the external strobe on exactly that edge. The strobe has to be ignored, because the old mode is still in force on that edge. The frame must still be 2430 cycles long, with the new source taking over only in the next frame. A cycle-accurate bench model judges every output on every cycle, including long random stretches where strobes, offsets above 2429 and mode flips land at arbitrary slots.

// File: rtl/sfg_pkg.sv
package sfg_pkg;

  typedef enum logic [1:0] {
    TM_DROP   = 2'd0,
    TM_EXT    = 2'd1,
    TM_ADDBUS = 2'd2
  } tmode_e;

  function automatic tmode_e decode_mode(logic add_sel, logic drop_sel);
    if (add_sel)  return TM_ADDBUS;
    if (drop_sel) return TM_DROP;
    return TM_EXT;
  endfunction

  // offsets outside the frame count as zero
  function automatic int clamp_offset(int off, int slots);
    return (off >= slots) ? 0 : off;
  endfunction

  function automatic int after_slot(int s, int slots);
    return (s + 1 >= slots) ? 0 : s + 1;
  endfunction

  function automatic int row_of(int s, int cols, int rows);
    int r;
    r = 0;
    for (int i = 1; i < rows; i++)
      if (s >= i * cols) r = i;
    return r;
  endfunction

  function automatic int col_of(int s, int cols, int rows);
    return s - row_of(s, cols, rows) * cols;
  endfunction

  // J1 slot for pointer 0 or the high pointer value
  function automatic int j1_slot(bit high, int cols, int rows, int toh,
                                 int ptr_row, int ptr_high, int step);
    int span, off, r, c;
    span = cols - toh;
    off  = high ? ptr_high * step : 0;
    r    = (ptr_row + off / span) % rows;
    c    = toh + off % span;
    return r * cols + c;
  endfunction

endpackage

// File: rtl/sfg_slot_counter.sv
module sfg_slot_counter
  import sfg_pkg::*;
#(
  parameter int COLS = 270,
  parameter int ROWS = 9,
  localparam int SLOTS = COLS * ROWS,
  localparam int SW = $clog2(SLOTS),
  localparam int CW = $clog2(COLS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [SW-1:0] load_slot,
  output logic [SW-1:0] slot,
  output logic [CW-1:0] col,
  output logic          frame_end
);

  assign frame_end = (slot == SW'(SLOTS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot <= '0;
      col  <= '0;
    end else if (load) begin
      slot <= load_slot;
      col  <= CW'(col_of(int'(load_slot), COLS, ROWS));
    end else if (frame_end) begin
      slot <= '0;
      col  <= '0;
    end else begin
      slot <= slot + 1'b1;
      col  <= (col == CW'(COLS - 1)) ? '0 : col + 1'b1;
    end
  end

endmodule

// File: rtl/sfg_slot_decode.sv
module sfg_slot_decode
  import sfg_pkg::*;
#(
  parameter int COLS = 270,
  parameter int ROWS = 9,
  parameter int TOH_COLS = 9,
  parameter int PTR_ROW = 3,
  parameter int PTR_HIGH = 522,
  parameter int PTR_STEP = 3,
  localparam int SLOTS = COLS * ROWS,
  localparam int SW = $clog2(SLOTS),
  localparam int CW = $clog2(COLS),
  localparam int J1_LOW  = j1_slot(1'b0, COLS, ROWS, TOH_COLS, PTR_ROW, PTR_HIGH, PTR_STEP),
  localparam int J1_HIGH = j1_slot(1'b1, COLS, ROWS, TOH_COLS, PTR_ROW, PTR_HIGH, PTR_STEP)
) (
  input  logic [SW-1:0] slot,
  input  logic [CW-1:0] col,
  input  logic          ptr_high_sel,
  output logic          is_c1,
  output logic          is_j1,
  output logic          in_toh
);

  assign is_c1  = (slot == '0);
  assign is_j1  = ptr_high_sel ? (slot == SW'(J1_HIGH)) : (slot == SW'(J1_LOW));
  assign in_toh = (col < CW'(TOH_COLS));

endmodule

// File: rtl/sfg_add_stage.sv
module sfg_add_stage #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_live,
  input  logic          c1_now,
  input  logic          c1j1_now,
  input  logic          spe_ind_now,
  input  logic          payload_now,
  input  logic          j1_now,
  input  logic [DW-1:0] din,
  output logic          c1_out,
  output logic          c1j1_out,
  output logic          spe_out,
  output logic          add_en_out,
  output logic [DW-1:0] dout,
  output logic          par_out
);

  logic          live;
  logic          en_now;
  logic [DW-1:0] data_nxt;

  assign en_now   = payload_now & (live | j1_now);
  assign data_nxt = en_now ? din : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live       <= 1'b0;
      c1_out     <= 1'b0;
      c1j1_out   <= 1'b0;
      spe_out    <= 1'b0;
      add_en_out <= 1'b0;
      dout       <= '0;
      par_out    <= 1'b1;
    end else begin
      live       <= clear_live ? 1'b0 : (live | j1_now);
      c1_out     <= c1_now;
      c1j1_out   <= c1j1_now;
      spe_out    <= spe_ind_now;
      add_en_out <= en_now;
      dout       <= data_nxt;
      par_out    <= ~^data_nxt;
    end
  end

endmodule

// File: rtl/sfg_add_timing.sv
module sfg_add_timing
  import sfg_pkg::*;
#(
  parameter int COLS = 270,
  parameter int ROWS = 9,
  parameter int TOH_COLS = 9,
  parameter int PTR_ROW = 3,
  parameter int PTR_HIGH = 522,
  parameter int PTR_STEP = 3,
  parameter int DW = 8,
  localparam int SLOTS = COLS * ROWS,
  localparam int SW = $clog2(SLOTS),
  localparam int CW = $clog2(COLS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tm_add_sel,
  input  logic          tm_drop_sel,
  input  logic          ptr_high_sel,
  input  logic          drop_c1,
  input  logic          ext_c1,
  input  logic [SW-1:0] ref_offset,
  input  logic          add_c1j1_in,
  input  logic          add_spe_in,
  input  logic [DW-1:0] add_data_in,
  output logic          c1_out,
  output logic          c1j1_out,
  output logic          spe_out,
  output logic          add_en_out,
  output logic [DW-1:0] add_data_out,
  output logic          parity_out
);

  tmode_e        req_mode, mode_q, eff_mode;
  logic          mode_valid;
  logic          frame_end, mode_switch;
  logic          gen_mode, ref_load, at_slot_zero;
  logic          bus_frame, bus_j1;
  logic [SW-1:0] slot, load_slot;
  logic [CW-1:0] col;
  logic          is_c1, is_j1, in_toh;

  // mode selection, deferred to the frame boundary
  assign req_mode    = decode_mode(tm_add_sel, tm_drop_sel);
  assign eff_mode    = mode_valid ? mode_q : req_mode;
  assign mode_switch = mode_valid && frame_end && (req_mode != mode_q);
  assign gen_mode    = (eff_mode != TM_ADDBUS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q     <= TM_DROP;
      mode_valid <= 1'b0;
    end else if (!mode_valid || mode_switch) begin
      mode_q     <= req_mode;
      mode_valid <= 1'b1;
    end
  end

  // frame reference selection
  assign bus_frame = add_c1j1_in & ~add_spe_in;
  assign bus_j1    = add_c1j1_in &  add_spe_in;
  assign ref_load  = ((eff_mode == TM_DROP) & drop_c1) |
                     ((eff_mode == TM_EXT)  & ext_c1)  |
                     ((eff_mode == TM_ADDBUS) & bus_frame);
  assign load_slot = (eff_mode == TM_ADDBUS) ? SW'(1)
                   : SW'(after_slot(clamp_offset(int'(ref_offset), SLOTS), SLOTS));
  assign at_slot_zero = (slot == '0);

  sfg_slot_counter #(.COLS(COLS), .ROWS(ROWS)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (ref_load),
    .load_slot (load_slot),
    .slot      (slot),
    .col       (col),
    .frame_end (frame_end)
  );

  sfg_slot_decode #(
    .COLS(COLS), .ROWS(ROWS), .TOH_COLS(TOH_COLS),
    .PTR_ROW(PTR_ROW), .PTR_HIGH(PTR_HIGH), .PTR_STEP(PTR_STEP)
  ) u_dec (
    .slot         (slot),
    .col          (col),
    .ptr_high_sel (ptr_high_sel),
    .is_c1        (is_c1),
    .is_j1        (is_j1),
    .in_toh       (in_toh)
  );

  sfg_add_stage #(.DW(DW)) u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear_live  (mode_switch),
    .c1_now      (gen_mode & is_c1),
    .c1j1_now    (gen_mode & (is_c1 | is_j1)),
    .spe_ind_now (gen_mode & ~in_toh),
    .payload_now (gen_mode ? ~in_toh : add_spe_in),
    .j1_now      (gen_mode ? is_j1 : bus_j1),
    .din         (add_data_in),
    .c1_out      (c1_out),
    .c1j1_out    (c1j1_out),
    .spe_out     (spe_out),
    .add_en_out  (add_en_out),
    .dout        (add_data_out),
    .par_out     (parity_out)
  );

endmodule

// File: rtl/sfg_add_timing_chk.sv
module sfg_add_timing_chk
  import sfg_pkg::*;
#(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    eff_mode,
  input logic [1:0]    mode_q,
  input logic          mode_valid,
  input logic          frame_end,
  input logic          at_slot_zero,
  input logic          c1_out,
  input logic          c1j1_out,
  input logic          spe_out,
  input logic          add_en_out,
  input logic [DW-1:0] add_data_out,
  input logic          parity_out
);

  a_r1_c1_at_slot_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (at_slot_zero && eff_mode != TM_ADDBUS) |=> c1_out);

  a_r2_no_spe_on_c1: assert property (@(posedge clk) disable iff (!rst_n)
    c1_out |-> !spe_out);

  a_r3_c1_in_c1j1: assert property (@(posedge clk) disable iff (!rst_n)
    c1_out |-> c1j1_out);

  a_r6_bus_mode_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_mode == TM_ADDBUS) |=> (!c1_out && !c1j1_out && !spe_out));

  a_r7_data_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !add_en_out |-> (add_data_out == '0));

  a_r8_odd_parity: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones({parity_out, add_data_out}) % 2) == 1);

  a_r9_switch_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_valid && !frame_end) |=> $stable(mode_q));

endmodule

bind sfg_add_timing sfg_add_timing_chk #(.DW(DW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .eff_mode     (eff_mode),
  .mode_q       (mode_q),
  .mode_valid   (mode_valid),
  .frame_end    (frame_end),
  .at_slot_zero (at_slot_zero),
  .c1_out       (c1_out),
  .c1j1_out     (c1j1_out),
  .spe_out      (spe_out),
  .add_en_out   (add_en_out),
  .add_data_out (add_data_out),
  .parity_out   (parity_out)
);

// File: tb/tb_sfg_add_timing.sv
`timescale 1ns/1ps
module tb_sfg_add_timing;

  localparam int NSLOT = 2430;
  localparam int NCOL  = 270;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tm_add_sel = 1'b0, tm_drop_sel = 1'b1, ptr_high_sel = 1'b0;
  logic        drop_c1 = 1'b0, ext_c1 = 1'b0;
  logic [11:0] ref_offset = '0;
  logic        add_c1j1_in = 1'b0, add_spe_in = 1'b0;
  logic [7:0]  add_data_in = '0;
  logic        c1_out, c1j1_out, spe_out, add_en_out, parity_out;
  logic [7:0]  add_data_out;

  always #2.5 clk = ~clk;

  sfg_add_timing dut (
    .clk(clk), .rst_n(rst_n), .tm_add_sel(tm_add_sel), .tm_drop_sel(tm_drop_sel),
    .ptr_high_sel(ptr_high_sel), .drop_c1(drop_c1), .ext_c1(ext_c1),
    .ref_offset(ref_offset), .add_c1j1_in(add_c1j1_in), .add_spe_in(add_spe_in),
    .add_data_in(add_data_in), .c1_out(c1_out), .c1j1_out(c1j1_out),
    .spe_out(spe_out), .add_en_out(add_en_out), .add_data_out(add_data_out),
    .parity_out(parity_out)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  task automatic chk(string tag, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // reference model built from the requirements: 0 drop, 1 ext, 2 add-bus
  function automatic int pin_mode(bit a, bit d);
    return a ? 2 : (d ? 0 : 1);
  endfunction

  int m_pos = 0, m_mode = 0, m_eff_prev = 0;
  bit m_valid = 0, m_live = 0;
  bit e_c1 = 0, e_c1j1 = 0, e_spe = 0, e_en = 0, e_par = 1;
  logic [7:0] e_data = '0;

  always @(posedge clk) begin
    int eff, off, nxt, req;
    bit spe, j1;
    if (!rst_n) begin
      m_pos = 0; m_mode = 0; m_valid = 0; m_live = 0;
      e_c1 = 0; e_c1j1 = 0; e_spe = 0; e_en = 0; e_data = '0; e_par = 1;
    end else begin
      req = pin_mode(tm_add_sel, tm_drop_sel);
      eff = m_valid ? m_mode : req;
      if (eff == 2) begin
        spe = add_spe_in; j1 = add_c1j1_in & add_spe_in;
        e_c1 = 0; e_c1j1 = 0; e_spe = 0;
      end else begin
        spe = (m_pos % NCOL) >= 9;
        j1 = (m_pos == (ptr_high_sel ? 9 : 3 * NCOL + 9));
        e_c1 = (m_pos == 0); e_c1j1 = e_c1 | j1; e_spe = spe;
      end
      e_en = spe & (m_live | j1);
      e_data = e_en ? add_data_in : 8'h00;
      e_par = ~^e_data;
      m_eff_prev = eff;
      off = (ref_offset >= NSLOT) ? 0 : int'(ref_offset);
      if (eff == 2 && add_c1j1_in && !add_spe_in) nxt = 1;
      else if ((eff == 0 && drop_c1) || (eff == 1 && ext_c1)) nxt = (off + 1) % NSLOT;
      else nxt = (m_pos + 1) % NSLOT;
      if (!m_valid) begin
        m_mode = req; m_valid = 1; m_live = m_live | j1;
      end else if (m_pos == NSLOT - 1 && req != m_mode) begin
        m_mode = req; m_live = 0;
      end else m_live = m_live | j1;
      m_pos = nxt;
    end
  end

  // every-cycle comparison, away from the active edge (R10: one-cycle registered timing)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      string ti;
      ti = (m_eff_prev == 2) ? "R6" : "";
      chk(m_eff_prev == 2 ? ti : "R1", "c1_out", c1_out, e_c1);
      chk(m_eff_prev == 2 ? ti : "R3", "c1j1_out", c1j1_out, e_c1j1);
      chk(m_eff_prev == 2 ? ti : "R2", "spe_out", spe_out, e_spe);
      chk("R7", "add_en_out", add_en_out, e_en);
      chk("R10", "add_data_out", add_data_out, e_data);
      chk("R8", "parity_out", parity_out, e_par);
    end
  end

  // add-bus frame source, used whenever add-bus timing is selected
  int ab_pos = 1234, ab_j1 = 900;
  always @(negedge clk) begin
    ab_pos = (ab_pos == NSLOT - 1) ? 0 : ab_pos + 1;
    if (ab_pos == 0) ab_j1 = NCOL * ($urandom % 9) + 9 + ($urandom % 261);
    add_c1j1_in <= (ab_pos == 0) || (ab_pos == ab_j1);
    add_spe_in  <= (ab_pos % NCOL) >= 9;
    add_data_in <= 8'($urandom);
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d expected <190000 cycles", cyc);
      finish_run();
    end
  end

  // cycles from one c1_out to the next, with an optional strobe and mode change
  task automatic gap_run(input bit p_drop, input bit p_ext, input int off, input int p_at,
                         input bit do_sw, input bit sw_add, input bit sw_drop, input int sw_at,
                         output int gap);
    @(negedge clk);
    while (!c1_out) @(negedge clk);
    gap = 0;
    do begin
      @(negedge clk);
      gap++;
      drop_c1 = p_drop && (gap == p_at);
      ext_c1  = p_ext && (gap == p_at);
      if (gap == p_at) ref_offset = 12'(off);
      if (do_sw && gap == sw_at) begin
        tm_add_sel = sw_add; tm_drop_sel = sw_drop;
      end
    end while (!c1_out && gap < 6000);
    drop_c1 = 0; ext_c1 = 0;
  endtask

  task automatic c1_to_j1(output int n);
    @(negedge clk);
    while (!c1_out) @(negedge clk);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!(c1j1_out && !c1_out) && n < 6000);
  endtask

  initial begin
    int g, cnt_c1, cnt_en;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    // R10 reset state
    chk("R10", "reset c1_out", c1_out, 0);
    chk("R10", "reset c1j1_out", c1j1_out, 0);
    chk("R10", "reset spe_out", spe_out, 0);
    chk("R7", "reset add_en_out", add_en_out, 0);
    chk("R10", "reset add_data_out", add_data_out, 0);
    chk("R8", "reset parity_out", parity_out, 1);
    rst_n = 1;

    // drop mode, free running
    gap_run(0, 0, 0, 0, 0, 0, 0, 0, g);  chk("R1", "free-run period", g, NSLOT);
    c1_to_j1(g);                           chk("R3", "J1 slot pointer 0", g, 819);
    ptr_high_sel = 1;
    c1_to_j1(g);                           chk("R3", "J1 slot pointer 522", g, 9);
    // drop reference with offsets
    gap_run(1, 0, 100, 50, 0, 0, 0, 0, g); chk("R4", "drop offset 100", g, 2381);
    gap_run(1, 0, 3000, 50, 0, 0, 0, 0, g); chk("R4", "drop offset clamp", g, 2481);
    gap_run(0, 1, 100, 50, 0, 0, 0, 0, g); chk("R5", "ext strobe ignored in drop", g, NSLOT);
    // mode change mid-frame waits for frame end
    gap_run(0, 0, 0, 0, 1, 0, 0, 100, g);  chk("R9", "no truncated frame", g, NSLOT);
    gap_run(1, 0, 100, 50, 0, 0, 0, 0, g); chk("R5", "drop strobe ignored in ext", g, NSLOT);
    gap_run(0, 1, 2429, 50, 0, 0, 0, 0, g); chk("R4", "ext offset 2429", g, 52);
    gap_run(0, 1, 0, 50, 0, 0, 0, 0, g);   chk("R4", "ext offset 0", g, 2481);
    // collision: frame end, mode request and strobe on one edge
    gap_run(0, 0, 0, 0, 1, 0, 1, 2000, g); chk("R9", "back to drop", g, NSLOT);
    gap_run(0, 1, 0, 2428, 1, 0, 0, 2428, g); chk("R9", "switch plus strobe at frame end", g, NSLOT);

    // add-bus mode
    tm_add_sel = 1;
    repeat (NSLOT + 10) @(negedge clk);
    cnt_c1 = 0; cnt_en = 0;
    repeat (2 * NSLOT) begin
      @(negedge clk);
      cnt_c1 += c1_out | c1j1_out | spe_out;
      cnt_en += add_en_out;
    end
    chk("R6", "indicators quiet in add-bus mode", cnt_c1, 0);
    chk("R7", "add lane active after J1", cnt_en > 0, 1);

    // random mix
    repeat (40000) begin
      @(negedge clk);
      drop_c1 = ($urandom % 1500) == 0;
      ext_c1  = ($urandom % 1500) == 0;
      ref_offset = 12'($urandom);
      if (($urandom % 4000) == 0) begin
        tm_add_sel = 1'($urandom); tm_drop_sel = 1'($urandom);
      end
      if (($urandom % 3000) == 0) ptr_high_sel = ~ptr_high_sel;
    end
    drop_c1 = 0; ext_c1 = 0;
    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule